// File: doc/BRIEF.md
# Programmable Parallel Port Interface

This block gives a host bus three byte-wide general-purpose ports (called A, B and C here) and one control location, reached through a chip select and a two-bit address. Each port, or each half of port C, is set as input or output by a configuration word written to the control location. An output port drives its latched byte onto its output pins and asserts its output-enable bits. An input port returns the sampled external pins when it is read.

A control write with bit 7 set is a configuration word. It is stored, it can be read back, and it clears every output latch. A control write with bit 7 clear instead sets or clears one bit of port C, so software can toggle single strobe or select lines without a read-modify-write. Only basic input/output behaviour is built. Strobed and bidirectional mode selections are stored and read back, but the ports still act as basic I/O.

Top module: `pio_port_ctrl`

## Requirements
- R1: After reset the control location reads 0x9B, every port latch holds 0xFF (visible on the output pins) and every output-enable bit is 0.
- R2: The address selects port A at 0, port B at 1, port C at 2 and control at 3. A write to a data address loads the byte into that port's latch, and an output port reads back its latch.
- R3: A control write with bit 7 = 1 stores the whole byte in the control register, and a read of address 3 returns it unchanged.
- R4: In the configuration word, bit 4 sets port A, bit 1 sets port B, bit 3 sets port C bits 7:4 and bit 0 sets port C bits 3:0. A 1 means input (enables 0), a 0 means output (enables all 1).
- R5: A read of a port, or of a half of port C, that is set as input returns the external input pins for those bits.
- R6: A configuration word write clears all three port latches to 0x00.
- R7: A control write with bit 7 = 0 writes bit 0 into port C bit number wdata[3:1]. All other port C bits and the control register stay unchanged.
- R8: Nothing changes unless chip select and write enable are both high at the clock edge.
- R9: Read data is combinational while chip select and read enable are both high, and is 0x00 otherwise.
- R10: With mode 1 or mode 2 selected (bit 2 = 1, or bits 6:5 non-zero), data writes, reads and output enables behave as in basic I/O.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| rd_en | input | 1 | Read enable |
| wr_en | input | 1 | Write enable |
| addr | input | 2 | Location select |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data |
| pa_in | input | DW | Port A external pins |
| pb_in | input | DW | Port B external pins |
| pc_in | input | DW | Port C external pins |
| pa_out | output | DW | Port A latch value |
| pb_out | output | DW | Port B latch value |
| pc_out | output | DW | Port C latch value |
| pa_oe | output | DW | Port A output enables |
| pb_oe | output | DW | Port B output enables |
| pc_oe | output | DW | Port C output enables |

## Verification
The hardest case to reach is a read of port C with its two halves set in opposite directions, where one nibble must come from the pins and the other from the latch. The stimulus writes a configuration that splits port C, loads a latch byte and drives pins that differ from it in both nibbles, so a read that takes either source alone gives a wrong value. The single-bit writes are checked in the same way, with a set and then a clear on a non-zero latch, followed by a read of the control location to show that it did not change.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int CTRL_W = 8;
  localparam logic [CTRL_W-1:0] CTRL_RST = 8'h9B;

  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_CTRL = 2'd3
  } pio_sel_e;

  localparam int BIT_CFG_FLAG = 7;
  localparam int DIR_CLO      = 0;
  localparam int DIR_B        = 1;
  localparam int DIR_CHI      = 3;
  localparam int DIR_A        = 4;
  localparam int NPORT        = 3;
endpackage

// File: rtl/pio_mode_reg.sv
module pio_mode_reg
  import pio_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl,
  output logic              cfg_ld,
  output logic              bit_wr
);
  assign cfg_ld = we &  wdata[BIT_CFG_FLAG];
  assign bit_wr = we & ~wdata[BIT_CFG_FLAG];

  always_ff @(posedge clk) begin
    if (rst)         ctrl <= CTRL_RST;
    else if (cfg_ld) ctrl <= wdata;
  end

  AST_CFG_STORED: assert property (@(posedge clk) disable iff (rst)
    cfg_ld |=> ctrl == $past(wdata)); // R3
  AST_BITWR_KEEPS_CTRL: assert property (@(posedge clk) disable iff (rst)
    bit_wr |=> $stable(ctrl)); // R7
endmodule

// File: rtl/pio_port_latch.sv
module pio_port_latch #(
  parameter int         W   = 8,
  parameter int         IW  = $clog2(W),
  parameter logic [W-1:0] RST = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic          clr,
  input  logic          bset,
  input  logic [IW-1:0] bidx,
  input  logic          bval,
  input  logic [W-1:0]  d,
  output logic [W-1:0]  q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= RST;
    else if (clr)  q <= '0;
    else if (ld)   q <= d;
    else if (bset) q[bidx] <= bval;
  end

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr |=> q == '0); // R6
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    (ld && !clr) |=> q == $past(d)); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !(ld || clr || bset) |=> $stable(q)); // R8
  AST_BIT_ONLY_ONE: assert property (@(posedge clk) disable iff (rst)
    (bset && !ld && !clr) |=> $countones(q ^ $past(q)) <= 1); // R7
endmodule

// File: rtl/pio_rd_mux.sv
module pio_rd_mux
  import pio_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                       rd_ok,
  input  logic [1:0]                 addr,
  input  logic [NPORT-1:0][DW-1:0]   lat,
  input  logic [NPORT-1:0][DW-1:0]   pins,
  input  logic [NPORT-1:0][DW-1:0]   in_mask,
  input  logic [CTRL_W-1:0]          ctrl,
  output logic [DW-1:0]              rdata
);
  logic [NPORT-1:0][DW-1:0] view;

  for (genvar g = 0; g < NPORT; g++) begin : g_view
    assign view[g] = (pins[g] & in_mask[g]) | (lat[g] & ~in_mask[g]);
  end

  always_comb begin
    rdata = '0;
    if (rd_ok) begin
      unique case (pio_sel_e'(addr))
        SEL_A:    rdata = view[0];
        SEL_B:    rdata = view[1];
        SEL_C:    rdata = view[2];
        SEL_CTRL: rdata = DW'(ctrl);
        default:  rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pio_port_ctrl.sv
module pio_port_ctrl
  import pio_pkg::*;
#(
  parameter int         DW       = 8,
  parameter logic [DW-1:0] PORT_RST = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pa_in,
  input  logic [DW-1:0] pb_in,
  input  logic [DW-1:0] pc_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] pa_oe,
  output logic [DW-1:0] pb_oe,
  output logic [DW-1:0] pc_oe
);
  localparam int IW = $clog2(DW);
  localparam int HI = DW - DW / 2;
  localparam int LO = DW / 2;

  logic                     wr_hit;
  logic [CTRL_W-1:0]        ctrl;
  logic                     cfg_ld;
  logic                     bit_wr;
  logic [NPORT-1:0][DW-1:0] lat;
  logic [NPORT-1:0][DW-1:0] pins;
  logic [NPORT-1:0][DW-1:0] in_mask;

  assign wr_hit = cs & wr_en;

  pio_mode_reg u_mode (
    .clk    (clk),
    .rst    (rst),
    .we     (wr_hit && pio_sel_e'(addr) == SEL_CTRL),
    .wdata  (wdata[CTRL_W-1:0]),
    .ctrl   (ctrl),
    .cfg_ld (cfg_ld),
    .bit_wr (bit_wr)
  );

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    pio_port_latch #(.W(DW), .IW(IW), .RST(PORT_RST)) u_latch (
      .clk  (clk),
      .rst  (rst),
      .ld   (wr_hit && addr == 2'(g)),
      .clr  (cfg_ld),
      .bset (bit_wr && g == int'(SEL_C)),
      .bidx (wdata[IW:1]),
      .bval (wdata[0]),
      .d    (wdata),
      .q    (lat[g])
    );
  end

  assign pins       = {pc_in, pb_in, pa_in};
  assign in_mask[0] = {DW{ctrl[DIR_A]}};
  assign in_mask[1] = {DW{ctrl[DIR_B]}};
  assign in_mask[2] = {{HI{ctrl[DIR_CHI]}}, {LO{ctrl[DIR_CLO]}}};

  pio_rd_mux #(.DW(DW)) u_rd (
    .rd_ok   (cs & rd_en),
    .addr    (addr),
    .lat     (lat),
    .pins    (pins),
    .in_mask (in_mask),
    .ctrl    (ctrl),
    .rdata   (rdata)
  );

  assign pa_out = lat[0];
  assign pb_out = lat[1];
  assign pc_out = lat[2];
  assign pa_oe  = ~in_mask[0];
  assign pb_oe  = ~in_mask[1];
  assign pc_oe  = ~in_mask[2];

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !(cs && rd_en) |-> rdata == '0); // R9
  AST_OE_A_FROM_CFG: assert property (@(posedge clk) disable iff (rst)
    cfg_ld |=> pa_oe == {DW{~$past(wdata[DIR_A])}}); // R4
  AST_OE_CHI_FROM_CFG: assert property (@(posedge clk) disable iff (rst)
    cfg_ld |=> pc_oe[DW-1] == ~$past(wdata[DIR_CHI])); // R4
endmodule

// File: tb/tb_pio_port_ctrl.sv
module tb_pio_port_ctrl;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [1:0]    addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [DW-1:0] pa_in = '0, pb_in = '0, pc_in = '0;
  logic [DW-1:0] pa_out, pb_out, pc_out, pa_oe, pb_oe, pc_oe;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  pio_port_ctrl #(.DW(DW)) dut (
    .clk(clk), .rst(rst), .cs(cs), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pb_in(pb_in), .pc_in(pc_in),
    .pa_out(pa_out), .pb_out(pb_out), .pc_out(pc_out),
    .pa_oe(pa_oe), .pb_oe(pb_oe), .pc_oe(pc_oe)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [DW-1:0] d,
                        input logic c = 1'b1, input logic w = 1'b1);
    @(negedge clk);
    cs = c; wr_en = w; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    cs = 1'b1; rd_en = 1'b1; addr = a;
    #1 d = rdata;
    cs = 1'b0; rd_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    bus_rd(2'd3, v);          check("R1 ctrl", v, 8'h9B);
    check("R1 pa_out", pa_out, 8'hFF);
    check("R1 pc_out", pc_out, 8'hFF);
    check("R1 oe", pa_oe | pb_oe | pc_oe, 8'h00);
    pa_in = 8'h5A; pb_in = 8'hC6;
    bus_rd(2'd0, v);          check("R5 input A", v, 8'h5A);
    bus_rd(2'd1, v);          check("R5 input B", v, 8'hC6);
  endtask

  task automatic t_all_out();
    logic [DW-1:0] v;
    bus_wr(2'd3, 8'h80);
    check("R4 oe A", pa_oe, 8'hFF);
    check("R4 oe C", pc_oe, 8'hFF);
    check("R6 clear A", pa_out, 8'h00);
    check("R6 clear B", pb_out, 8'h00);
    bus_rd(2'd3, v);          check("R3 cfg readback", v, 8'h80);
    bus_wr(2'd0, 8'h3C); bus_wr(2'd1, 8'hC3); bus_wr(2'd2, 8'h81);
    check("R2 pa_out", pa_out, 8'h3C);
    check("R2 pb_out", pb_out, 8'hC3);
    check("R2 pc_out", pc_out, 8'h81);
    bus_rd(2'd0, v);          check("R2 read A latch", v, 8'h3C);
    bus_rd(2'd2, v);          check("R2 read C latch", v, 8'h81);
    bus_wr(2'd3, 8'h80);
    check("R6 reclear C", pc_out, 8'h00);
  endtask

  task automatic t_split_c();
    logic [DW-1:0] v;
    bus_wr(2'd3, 8'h88);
    check("R4 C hi input", pc_oe, 8'h0F);
    bus_wr(2'd2, 8'hA5);
    pc_in = 8'h3C;
    bus_rd(2'd2, v);          check("R5 split C hi in", v, 8'h35);
    bus_wr(2'd3, 8'h81);
    check("R4 C lo input", pc_oe, 8'hF0);
    bus_wr(2'd2, 8'hA5);
    bus_rd(2'd2, v);          check("R5 split C lo in", v, 8'hAC);
    bus_wr(2'd3, 8'h92);
    check("R4 A input", pa_oe, 8'h00);
    check("R4 B input", pb_oe, 8'h00);
    check("R4 C output", pc_oe, 8'hFF);
  endtask

  task automatic t_bit_ops();
    logic [DW-1:0] v;
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd2, 8'h10);
    bus_wr(2'd3, 8'h0F);      check("R7 set bit7", pc_out, 8'h90);
    bus_wr(2'd3, 8'h05);      check("R7 set bit2", pc_out, 8'h94);
    bus_wr(2'd3, 8'h08);      check("R7 clear bit4", pc_out, 8'h84);
    bus_wr(2'd3, 8'h04);      check("R7 clear bit2", pc_out, 8'h80);
    bus_rd(2'd3, v);          check("R7 ctrl kept", v, 8'h80);
    check("R7 A untouched", pa_out, 8'h00);
  endtask

  task automatic t_gating();
    bus_wr(2'd0, 8'h77);
    bus_wr(2'd0, 8'h11, 1'b0, 1'b1); check("R8 no cs", pa_out, 8'h77);
    bus_wr(2'd0, 8'h22, 1'b1, 1'b0); check("R8 no wr_en", pa_out, 8'h77);
    bus_wr(2'd3, 8'h80, 1'b0, 1'b1); check("R8 cfg no cs", pa_out, 8'h77);
    @(negedge clk);
    cs = 1'b1; addr = 2'd0; #1;
    check("R9 idle rdata", rdata, 8'h00);
    cs = 1'b0; rd_en = 1'b1; #1;
    check("R9 no cs rdata", rdata, 8'h00);
    rd_en = 1'b0;
  endtask

  task automatic t_other_modes();
    logic [DW-1:0] v;
    bus_wr(2'd3, 8'hE4);
    bus_rd(2'd3, v);          check("R3 mode2 stored", v, 8'hE4);
    check("R10 oe A", pa_oe, 8'hFF);
    bus_wr(2'd0, 8'h6D);
    bus_rd(2'd0, v);          check("R10 read A", v, 8'h6D);
    check("R10 pa_out", pa_out, 8'h6D);
    bus_wr(2'd3, 8'hA6);
    bus_rd(2'd3, v);          check("R3 mode1 stored", v, 8'hA6);
    pb_in = 8'h39;
    bus_rd(2'd1, v);          check("R10 B input", v, 8'h39);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 20000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_all_out();
    t_split_c();
    t_bit_ops();
    t_gating();
    t_other_modes();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule